// File: doc/BRIEF.md
# Fine-Edge PWM Extension

This block sits between two PWM timer channels and the output port they share. It places each compare edge more finely than one timer clock period. The block runs on a fast clock at four times the timers' peripheral clock. A single-cycle strobe on the fast clock marks the first fast cycle of every peripheral cycle. At each strobe the block samples the inputs for that peripheral cycle: each timer's count, its compare value (which carries extra fractional bits), and its base waveform level. It then replays that peripheral cycle on the output port in fast-clock slots.

In the cycle where a timer's count equals the integer part of its compare value, the output keeps the previous cycle's level for a fraction of the cycle, then takes the new level. The fraction is set by the compare value's low bits. There are two resolution modes. The normal mode uses four quarter-cycle slots. The plus mode uses eight half-slots, driven from one posedge flop and one negedge flop whose outputs are muxed by the clock phase. A small control byte selects the mode and the channels. Writes to the control byte are held until the next peripheral boundary.

Top module: `hr_edge_ext`

## Requirements
- R1: While reset is high and after its release, `wave_out` is 0, `ctl_rdata` is 0x00 and `hr_active` is 0.
- R2: The control byte holds the plus flag in bit 2 and the channel-enable field in bits 1:0. `ctl_rdata` returns the last written byte with bits 7:3 forced to zero, starting from the clock edge after the write.
- R3: A control write is committed at the first strobe-sampling edge after the write edge, and it governs the peripheral cycle that starts there. `hr_active` is 1 exactly when the committed enable field is nonzero, and it changes only at strobe edges.
- R4: Enable field decoding: 00 enables no channel, 01 enables channel 0 only, 10 enables channel 1 only, and 11 enables both. A channel that is not enabled never shifts its edge.
- R5: Normal mode (bit 2 = 0) uses integer part = compare >> 2 and fraction f = compare[1:0]. If the channel is enabled and its count equals the integer part, fast slots 0..f-1 of that peripheral cycle show the previous cycle's level, and slots f..3 show the new level.
- R6: Plus mode (bit 2 = 1) uses integer part = compare >> 3 and position p = compare[2:0], counted in half-slots. Half-slot 2s is the high phase and half-slot 2s+1 the low phase of fast slot s. In the matching cycle, half-slots below p show the previous level and the rest show the new level.
- R7: Minimum pulse: when the integer part is zero (compare below 4 in normal mode, or below 8 in plus mode), no edge is shifted, so no pulse shorter than one peripheral cycle appears.
- R8: In any cycle without a shifted edge, including cycles with the enable field at 00, each channel's output equals its base waveform level for all four fast slots. Slot 0 starts at the edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk4 | input | 1 | Fast clock, four times the peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| per_stb | input | 1 | High during the first fast cycle of each peripheral cycle |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data (bits 7:3 read as zero) |
| tmr_cnt | input | 2*CNT_W | Timer counts, channel 0 in the low slice |
| tmr_cmp | input | 2*(CNT_W+3) | Compare values with fractional bits, channel 0 in the low slice |
| wave_req | input | 2 | Base waveform levels from the timers |
| wave_out | output | 2 | Refined port waveform |
| hr_active | output | 1 | Port is in fine-edge output form |

## Verification
A control commit and a matched compare cycle can fall on the same strobe edge. The newly committed mode and enables must then decide how that cycle's edge is placed. The bench writes the plus-mode setting and, with no priming cycle between, starts a matching peripheral cycle. It then compares all eight half-slots of both channels against a half-slot pattern worked out from the new setting. The same pattern is never produced by the old setting, so a commit that lands one boundary late is caught.

// File: rtl/hr_edge_pkg.sv
`timescale 1ns/1ps
package hr_edge_pkg;
    localparam int N_CH     = 2;
    localparam int FRAC_MAX = 3;
    localparam int HALF_W   = 3;
    localparam int SLOT_W   = 2;
    localparam int CTL_W    = 8;
    localparam logic [CTL_W-1:0] CTL_MASK = 8'h07;

    typedef struct packed {
        logic       plus;
        logic [1:0] en;
    } hr_cfg_t;

    typedef struct packed {
        logic              fine;
        logic              lvl_prev;
        logic              lvl_new;
        logic [HALF_W-1:0] edge_pos;
    } edge_desc_t;

    function automatic logic half_level(input edge_desc_t d, input logic [HALF_W-1:0] h);
        return (d.fine && (h < d.edge_pos)) ? d.lvl_prev : d.lvl_new;
    endfunction
endpackage

// File: rtl/hr_edge_ctl.sv
`timescale 1ns/1ps
module hr_edge_ctl
    import hr_edge_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             per_stb,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output hr_cfg_t          cfg_pend,
    output hr_cfg_t          cfg_act
);
    logic [CTL_W-1:0] pend_q;
    hr_cfg_t          act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (we)
                pend_q <= wdata & CTL_MASK;
            if (per_stb)
                act_q <= hr_cfg_t'(pend_q[2:0]);
        end
    end

    assign rdata    = pend_q;
    assign cfg_pend = hr_cfg_t'(pend_q[2:0]);
    assign cfg_act  = act_q;
endmodule

// File: rtl/hr_edge_slot.sv
`timescale 1ns/1ps
module hr_edge_slot
    import hr_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              per_stb,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SLOT_W-1:0] slot_nx
);
    always_comb slot_nx = per_stb ? '0 : SLOT_W'(slot_q + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_nx;
    end
endmodule

// File: rtl/hr_edge_lane.sv
`timescale 1ns/1ps
module hr_edge_lane
    import hr_edge_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      per_stb,
    input  logic [SLOT_W-1:0]         slot_q,
    input  logic [SLOT_W-1:0]         slot_nx,
    input  logic                      plus,
    input  logic                      ch_en,
    input  logic [CNT_W-1:0]          cnt,
    input  logic [CNT_W+FRAC_MAX-1:0] cmp,
    input  logic                      req,
    output logic                      pos_lvl,
    output logic                      wave
);
    localparam int CMP_W = CNT_W + FRAC_MAX;
    localparam int INT_W = CNT_W + 1;

    logic [INT_W-1:0]  int_part;
    logic [INT_W-1:0]  cnt_x;
    logic [HALF_W-1:0] pos;
    edge_desc_t        cap, desc_q, desc_nx;
    logic              pos_q, neg_q;

    // integer part and edge position depend on the resolution mode
    always_comb begin
        if (plus) begin
            int_part = {1'b0, cmp[CMP_W-1:3]};
            pos      = cmp[2:0];
        end else begin
            int_part = cmp[CMP_W-1:2];
            pos      = {cmp[1:0], 1'b0};
        end
        cnt_x = {1'b0, cnt};
    end

    always_comb begin
        cap.fine     = ch_en && (int_part != '0) && (int_part == cnt_x);
        cap.lvl_prev = desc_q.lvl_new;
        cap.lvl_new  = req;
        cap.edge_pos = pos;
        desc_nx      = per_stb ? cap : desc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
            pos_q  <= 1'b0;
        end else begin
            desc_q <= desc_nx;
            pos_q  <= half_level(desc_nx, {slot_nx, 1'b0});
        end
    end

    always_ff @(negedge clk) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= half_level(desc_q, {slot_q, 1'b1});
    end

    // high phase carries the even half-slot, low phase the odd one
    assign wave    = clk ? pos_q : neg_q;
    assign pos_lvl = pos_q;
endmodule

// File: rtl/hr_edge_ext.sv
`timescale 1ns/1ps
module hr_edge_ext
    import hr_edge_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                             clk4,
    input  logic                             rst,
    input  logic                             per_stb,
    input  logic                             ctl_we,
    input  logic [7:0]                       ctl_wdata,
    output logic [7:0]                       ctl_rdata,
    input  logic [2*CNT_W-1:0]               tmr_cnt,
    input  logic [2*(CNT_W+3)-1:0]           tmr_cmp,
    input  logic [1:0]                       wave_req,
    output logic [1:0]                       wave_out,
    output logic                             hr_active
);
    localparam int CMP_W = CNT_W + FRAC_MAX;

    hr_cfg_t           cfg_pend, cfg_act;
    logic [SLOT_W-1:0] slot_q, slot_nx;
    logic [N_CH-1:0]   pos_lvl;
    logic [N_CH-1:0]   act_en;

    hr_edge_ctl u_ctl (
        .clk      (clk4),
        .rst      (rst),
        .per_stb  (per_stb),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .rdata    (ctl_rdata),
        .cfg_pend (cfg_pend),
        .cfg_act  (cfg_act)
    );

    hr_edge_slot u_slot (
        .clk     (clk4),
        .rst     (rst),
        .per_stb (per_stb),
        .slot_q  (slot_q),
        .slot_nx (slot_nx)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_lane
        hr_edge_lane #(.CNT_W(CNT_W)) u_lane (
            .clk     (clk4),
            .rst     (rst),
            .per_stb (per_stb),
            .slot_q  (slot_q),
            .slot_nx (slot_nx),
            .plus    (cfg_pend.plus),
            .ch_en   (cfg_pend.en[i]),
            .cnt     (tmr_cnt[i*CNT_W +: CNT_W]),
            .cmp     (tmr_cmp[i*CMP_W +: CMP_W]),
            .req     (wave_req[i]),
            .pos_lvl (pos_lvl[i]),
            .wave    (wave_out[i])
        );
    end

    assign act_en    = cfg_act.en;
    assign hr_active = |cfg_act.en;
endmodule

// File: rtl/hr_edge_ext_chk.sv
`timescale 1ns/1ps
module hr_edge_ext_chk #(
    parameter int NCH = 2
) (
    input logic           clk4,
    input logic           rst,
    input logic           per_stb,
    input logic           ctl_we,
    input logic [2:0]     wr_lo,
    input logic [7:0]     ctl_rdata,
    input logic           hr_active,
    input logic [NCH-1:0] act_en,
    input logic [NCH-1:0] pos_lvl
);
    // R2
    rdata_follows_write_chk: assert property (@(posedge clk4) disable iff (rst)
        ctl_we |=> ctl_rdata == {5'b0, $past(wr_lo)});

    // R3
    active_holds_between_strobes_chk: assert property (@(posedge clk4) disable iff (rst)
        !$past(per_stb) |-> $stable(hr_active));

    // R3
    active_commit_chk: assert property (@(posedge clk4) disable iff (rst)
        $past(per_stb) |-> hr_active == ($past(ctl_rdata[1:0]) != 2'b00));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R4
        idle_lane_steady_chk: assert property (@(posedge clk4) disable iff (rst)
            (!$past(per_stb) && !act_en[i]) |-> $stable(pos_lvl[i]));
    end
endmodule

bind hr_edge_ext hr_edge_ext_chk #(.NCH(2)) u_chk (
    .clk4      (clk4),
    .rst       (rst),
    .per_stb   (per_stb),
    .ctl_we    (ctl_we),
    .wr_lo     (ctl_wdata[2:0]),
    .ctl_rdata (ctl_rdata),
    .hr_active (hr_active),
    .act_en    (act_en),
    .pos_lvl   (pos_lvl)
);

// File: tb/hr_edge_ext_bench.sv
`timescale 1ns/1ps
module hr_edge_ext_bench;
    localparam int CNT_W = 16;
    localparam int CMP_W = CNT_W + 3;

    typedef struct packed {
        logic [3:0]       rq;
        logic [2:0]       ctl;
        logic [CNT_W-1:0] cnt;
        logic [CMP_W-1:0] cmp;
        logic             prev;
        logic             req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd4, 3'b001, 16'd5, 19'd22, 1'b1, 1'b0},  // R4 R5: ch0 only, f=2
        '{4'd4, 3'b010, 16'd5, 19'd22, 1'b1, 1'b0},  // R4: ch1 only
        '{4'd5, 3'b011, 16'd7, 19'd31, 1'b0, 1'b1},  // R5: rising edge, f=3
        '{4'd6, 3'b111, 16'd5, 19'd45, 1'b1, 1'b0},  // R6: plus, p=5
        '{4'd6, 3'b101, 16'd5, 19'd41, 1'b1, 1'b0},  // R6 R4: plus, p=1, ch0 only
        '{4'd7, 3'b011, 16'd0, 19'd3,  1'b1, 1'b0},  // R7: normal, compare below 4
        '{4'd7, 3'b111, 16'd0, 19'd7,  1'b1, 1'b0},  // R7: plus, compare below 8
        '{4'd8, 3'b011, 16'd6, 19'd22, 1'b1, 1'b0},  // R8: count mismatch
        '{4'd8, 3'b000, 16'd5, 19'd22, 1'b1, 1'b0},  // R8: field 00 pass-through
        '{4'd5, 3'b011, 16'd5, 19'd20, 1'b1, 1'b0},  // R5: f=0, edge at boundary
        '{4'd6, 3'b111, 16'd2, 19'd23, 1'b1, 1'b0},  // R6: p=7, last half-slot
        '{4'd8, 3'b001, 16'd9, 19'd37, 1'b1, 1'b1}   // R8: level unchanged
    };

    logic                 clk4 = 1'b0;
    logic                 rst = 1'b1;
    logic                 per_stb = 1'b0;
    logic                 ctl_we = 1'b0;
    logic [7:0]           ctl_wdata = '0;
    logic [7:0]           ctl_rdata;
    logic [2*CNT_W-1:0]   tmr_cnt = '0;
    logic [2*CMP_W-1:0]   tmr_cmp = '0;
    logic [1:0]           wave_req = '0;
    logic [1:0]           wave_out;
    logic                 hr_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk4 = ~clk4;

    hr_edge_ext #(.CNT_W(CNT_W)) u_hr_edge_ext (
        .clk4      (clk4),
        .rst       (rst),
        .per_stb   (per_stb),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .tmr_cnt   (tmr_cnt),
        .tmr_cmp   (tmr_cmp),
        .wave_req  (wave_req),
        .wave_out  (wave_out),
        .hr_active (hr_active)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(posedge clk4);
        #3;
        ctl_we = 1'b0;
    endtask

    // one peripheral cycle; collects the eight half-slots of both channels
    task automatic periph(input logic [CNT_W-1:0] c, input logic [CMP_W-1:0] m,
                          input logic r, output logic [7:0] g0, output logic [7:0] g1);
        per_stb  = 1'b1;
        tmr_cnt  = {c, c};
        tmr_cmp  = {m, m};
        wave_req = {r, r};
        for (int s = 0; s < 4; s++) begin
            @(posedge clk4);
            #1;
            g0[2*s] = wave_out[0];
            g1[2*s] = wave_out[1];
            #1;
            per_stb = 1'b0;
            #1;
            g0[2*s+1] = wave_out[0];
            g1[2*s+1] = wave_out[1];
        end
    endtask

    function automatic logic [7:0] expect_halves(input vec_t v, input int ch);
        logic [7:0]       res;
        logic [CNT_W:0]   ip;
        logic [2:0]       p;
        logic             fine;
        if (v.ctl[2]) begin
            ip = {1'b0, v.cmp[CMP_W-1:3]};
            p  = v.cmp[2:0];
        end else begin
            ip = v.cmp[CMP_W-1:2];
            p  = {v.cmp[1:0], 1'b0};
        end
        fine = v.ctl[ch] && (ip != '0) && (ip == {1'b0, v.cnt});
        for (int h = 0; h < 8; h++)
            res[h] = (fine && (h < int'(p))) ? v.prev : v.req;
        return res;
    endfunction

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] g0, g1;
        repeat (4) @(posedge clk4);
        #3;
        // R1: values during reset
        chk("R1 wave_out in reset", {6'b0, wave_out}, 8'h00);
        chk("R1 rdata in reset", ctl_rdata, 8'h00);
        chk("R1 hr_active in reset", {7'b0, hr_active}, 8'h00);
        rst = 1'b0;
        @(posedge clk4);
        #3;
        chk("R1 wave_out after reset", {6'b0, wave_out}, 8'h00);

        // R2 R3: write without a strobe is visible but not committed
        wr(8'h01);
        chk("R2 readback", ctl_rdata, 8'h01);
        chk("R3 no commit before strobe", {7'b0, hr_active}, 8'h00);
        wr(8'hFF);
        chk("R2 upper bits read zero", ctl_rdata, 8'h07);
        periph(16'hFFFF, 19'd0, 1'b0, g0, g1);
        chk("R3 commit at strobe", {7'b0, hr_active}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            wr({5'b0, VECS[i].ctl});
            periph(16'hFFFF, VECS[i].cmp, VECS[i].prev, g0, g1);
            periph(VECS[i].cnt, VECS[i].cmp, VECS[i].req, g0, g1);
            chk($sformatf("R%0d vector %0d ch0", VECS[i].rq, i), g0, expect_halves(VECS[i], 0));
            chk($sformatf("R%0d vector %0d ch1", VECS[i].rq, i), g1, expect_halves(VECS[i], 1));
            chk($sformatf("R3 vector %0d hr_active", i), {7'b0, hr_active},
                {7'b0, |VECS[i].ctl[1:0]});
        end

        // R3: commit lands on the same boundary as a matched cycle (prev level is 1)
        wr(8'h07);
        periph(16'd5, 19'd45, 1'b0, g0, g1);
        chk("R3 commit with match ch0", g0, 8'h1F);
        chk("R3 commit with match ch1", g1, 8'h1F);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule